// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a small unpipelined 32-bit processor with separate instruction and data memory ports. In each clock cycle it presents the program counter on the instruction port and receives one 32-bit instruction. A purely combinational decoder turns the opcode, the function field and a zero test into datapath selects. The core reads two general registers, computes a result in the ALU and, for loads and stores, reaches data memory through its combinational read port. The program counter, the register file and the memory write all take effect on the next rising clock edge.

The supported instructions are register-register ALU operations, register-immediate ALU operations, word loads and stores, branches on a zero or nonzero register, and absolute and register-indirect jumps with optional linking. Control transfers take effect at once, with no delay slot. The memories themselves live outside the block. The instruction port is read combinationally. The data port is written at the clock edge when the write enable is high.

Top module: `rcore_top`

## Requirements
- R1: While `rst_n` is low at a rising edge, the PC becomes 0 on that edge, and `dmem_we` stays low for as long as `rst_n` is low.
- R2: `imem_addr` equals the PC. Any instruction that does not transfer control advances the PC by 4.
- R3: R-format (opcode[31:26]=0, rs[25:21], rt[20:16], rd[15:11], shamt[10:6]=0, func[5:0]) writes rs op rt into rd. Function codes: 0x20 add, 0x22 subtract, 0x24 and, 0x25 or, 0x26 xor, 0x2A signed set-less-than.
- R4: I-format (rs[25:21], rt[20:16], imm[15:0]) writes into rt. Opcode 0x08 adds and 0x0A does signed set-less-than, both with the sign-extended immediate. Opcodes 0x0C, 0x0D and 0x0E do and, or and xor with the zero-extended immediate. Opcode 0x0F writes imm shifted into the upper 16 bits with zeros below.
- R5: Register 0 always reads as zero, and any write aimed at it is discarded.
- R6: Load word (opcode 0x23) reads data memory at rs + sign-extended imm into rt. Store word (opcode 0x2B) drives that address, drives rt as write data, asserts `dmem_we` and writes no register.
- R7: Opcode 0x04 branches when rs is zero and opcode 0x05 branches when rs is nonzero. The target is PC+4 + (sign-extended imm << 2). An untaken branch falls through to PC+4. Branches write neither a register nor memory.
- R8: Opcode 0x02 jumps and opcode 0x03 jumps and links. The target is {PC+4[31:28], instr[25:0], 2'b00}. The linking form writes PC+4 into register 31.
- R9: R-format function 0x08 sets the PC to rs. Function 0x09 does the same and also writes the old PC+4 into register 31.
- R10: An unknown opcode, an unknown R-format function, or a nonzero shamt field writes neither a register nor memory and advances the PC by 4.
- R11: A register written by one instruction supplies the new value to the very next instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| imem_addr | output | 32 | Byte address of the current instruction (the PC) |
| imem_data | input | 32 | Instruction word returned combinationally |
| dmem_addr | output | 32 | Byte address for a load or store |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store enable, sampled at the rising edge |
| dmem_rdata | input | 32 | Load data returned combinationally |

## Verification
The embedded assertions check the following on every cycle: sequential PC advance, taken-branch targets computed from the instruction fields, the link write of the jump-and-link form, that stores write no register, that undefined encodings stay silent, and that register 0 reads as zero. Other behaviour only the bench's program can show. This includes the arithmetic results of every operation over a grid of boundary operands, the three immediate extensions, load data reaching the destination, untaken branches and backward loops, and the final contents of data memory. The bench runs a reference instruction-level model in lockstep and compares the PC and every memory access each cycle. It then dumps all registers through stores.

// File: rtl/rcore_pkg.sv
// Shared encodings and control types for the single-cycle core.
// Assumes a fixed 32-bit instruction word; opcode/function values are
// the block's instruction encoding and must match the program image.
package rcore_pkg;

    localparam int XLEN = 32;

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] OP_J     = 6'h02;
    localparam logic [5:0] OP_JAL   = 6'h03;
    localparam logic [5:0] OP_BEQZ  = 6'h04;
    localparam logic [5:0] OP_BNEZ  = 6'h05;
    localparam logic [5:0] OP_ADDI  = 6'h08;
    localparam logic [5:0] OP_SLTI  = 6'h0A;
    localparam logic [5:0] OP_ANDI  = 6'h0C;
    localparam logic [5:0] OP_ORI   = 6'h0D;
    localparam logic [5:0] OP_XORI  = 6'h0E;
    localparam logic [5:0] OP_LUI   = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2B;

    localparam logic [5:0] FN_JR    = 6'h08;
    localparam logic [5:0] FN_JALR  = 6'h09;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] FN_SUB   = 6'h22;
    localparam logic [5:0] FN_AND   = 6'h24;
    localparam logic [5:0] FN_OR    = 6'h25;
    localparam logic [5:0] FN_XOR   = 6'h26;
    localparam logic [5:0] FN_SLT   = 6'h2A;

    typedef enum logic [1:0] {EXT_SIGN, EXT_ZERO, EXT_HIGH} ext_e;
    typedef enum logic       {B_REG, B_IMM} bsrc_e;
    typedef enum logic [2:0] {ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR,
                              ALU_SLT, ALU_PASSA, ALU_PASSB} alu_e;
    typedef enum logic [1:0] {WB_ALU, WB_MEM, WB_PC4} wb_e;
    typedef enum logic [1:0] {DST_RT, DST_RD, DST_LINK} dst_e;
    typedef enum logic [1:0] {PC_SEQ, PC_BR, PC_IND, PC_ABS} pcsrc_e;

    typedef struct packed {
        ext_e   ext_sel;
        bsrc_e  b_src;
        alu_e   alu_op;
        logic   mem_we;
        logic   reg_we;
        wb_e    wb_src;
        dst_e   reg_dst;
        pcsrc_e pc_src;
        logic   illegal;
    } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
// Hardwired control: maps opcode, function, shamt and the ALU zero flag
// to every datapath select in one combinational step.
// Assumes the zero flag reflects rs when the ALU passes operand A.
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] func,
    input  logic [4:0] shamt,
    input  logic       zero,
    output ctrl_t      ctrl
);

    // Decode the instruction class into control selects.
    always_comb begin
        ctrl.ext_sel = EXT_SIGN;
        ctrl.b_src   = B_REG;
        ctrl.alu_op  = ALU_ADD;
        ctrl.mem_we  = 1'b0;
        ctrl.reg_we  = 1'b0;
        ctrl.wb_src  = WB_ALU;
        ctrl.reg_dst = DST_RT;
        ctrl.pc_src  = PC_SEQ;
        ctrl.illegal = 1'b0;
        unique case (opcode)
            OP_RTYPE: begin
                if (shamt != 5'd0) begin
                    ctrl.illegal = 1'b1;
                end else begin
                    ctrl.reg_dst = DST_RD;
                    unique case (func)
                        FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                        FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                        FN_AND: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_AND; end
                        FN_OR:  begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_OR;  end
                        FN_XOR: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_XOR; end
                        FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                        FN_JR:  ctrl.pc_src = PC_IND;
                        FN_JALR: begin
                            ctrl.pc_src  = PC_IND;
                            ctrl.reg_we  = 1'b1;
                            ctrl.reg_dst = DST_LINK;
                            ctrl.wb_src  = WB_PC4;
                        end
                        default: ctrl.illegal = 1'b1;
                    endcase
                end
            end
            OP_ADDI: begin ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
            OP_SLTI: begin ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
            OP_ANDI: begin
                ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1;
                ctrl.ext_sel = EXT_ZERO; ctrl.alu_op = ALU_AND;
            end
            OP_ORI: begin
                ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1;
                ctrl.ext_sel = EXT_ZERO; ctrl.alu_op = ALU_OR;
            end
            OP_XORI: begin
                ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1;
                ctrl.ext_sel = EXT_ZERO; ctrl.alu_op = ALU_XOR;
            end
            OP_LUI: begin
                ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1;
                ctrl.ext_sel = EXT_HIGH; ctrl.alu_op = ALU_PASSB;
            end
            OP_LW: begin
                ctrl.b_src = B_IMM; ctrl.reg_we = 1'b1; ctrl.wb_src = WB_MEM;
            end
            OP_SW: begin ctrl.b_src = B_IMM; ctrl.mem_we = 1'b1; end
            OP_BEQZ: begin
                ctrl.alu_op = ALU_PASSA;
                ctrl.pc_src = zero ? PC_BR : PC_SEQ;
            end
            OP_BNEZ: begin
                ctrl.alu_op = ALU_PASSA;
                ctrl.pc_src = zero ? PC_SEQ : PC_BR;
            end
            OP_J:    ctrl.pc_src = PC_ABS;
            OP_JAL: begin
                ctrl.pc_src  = PC_ABS;
                ctrl.reg_we  = 1'b1;
                ctrl.reg_dst = DST_LINK;
                ctrl.wb_src  = WB_PC4;
            end
            default: ctrl.illegal = 1'b1;
        endcase
    end

endmodule

// File: rtl/rcore_alu.sv
// Combinational ALU with a zero flag on the result.
// Assumes operands are already selected and extended by the datapath.
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_e         op,
    output logic [W-1:0] y,
    output logic         zero
);

    // Select the operation result.
    always_comb begin
        unique case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_XOR:   y = a ^ b;
            ALU_SLT:   y = ($signed(a) < $signed(b)) ? W'(1) : '0;
            ALU_PASSA: y = a;
            default:   y = b;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/rcore_regfile.sv
// Two-read, one-write register file. Entry 0 is a constant zero with no
// storage; writes to it are dropped. Reads are combinational, writes land
// on the rising edge. Synchronous active-low reset clears all entries.
module rcore_regfile #(
    parameter int NREG = 32,
    parameter int W    = 32,
    localparam int AW  = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra_addr,
    output logic [W-1:0]  ra_data,
    input  logic [AW-1:0] rb_addr,
    output logic [W-1:0]  rb_data,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);

    logic [NREG*W-1:0] flat;

    assign flat[W-1:0] = '0;

    for (genvar i = 1; i < NREG; i++) begin : g_reg
        logic [W-1:0] q;
        // Hold register i, loading it when it is the write target.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q <= '0;
            else if (we && (waddr == AW'(i)))
                q <= wdata;
        end
        assign flat[i*W +: W] = q;
    end

    assign ra_data = flat[ra_addr*W +: W];
    assign rb_data = flat[rb_addr*W +: W];

    // R5
    r0_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_addr == '0) |-> (ra_data == '0));

endmodule

// File: rtl/rcore_top.sv
// Single-cycle core: fetch, decode, register read, ALU, memory access and
// write-back complete within one clock; PC, registers and memory update
// on the next rising edge. Assumes both memories answer combinationally.
module rcore_top
    import rcore_pkg::*;
#(
    parameter int          NREG     = 32,
    parameter logic [31:0] RESET_PC = 32'h0
) (
    input  logic        clk,
    input  logic        rst_n,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_data,
    output logic [31:0] dmem_addr,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we,
    input  logic [31:0] dmem_rdata
);

    localparam int AW = $clog2(NREG);

    logic [31:0] pc, pc_plus4, pc_next;
    logic [31:0] rs_val, rt_val, imm_ext, b_opnd, alu_y, wb_data;
    logic [AW-1:0] rf_waddr;
    logic        rf_we, zero;
    ctrl_t       ctrl;

    wire [5:0]  opcode = imem_data[31:26];
    wire [4:0]  rs     = imem_data[25:21];
    wire [4:0]  rt     = imem_data[20:16];
    wire [4:0]  rd     = imem_data[15:11];
    wire [4:0]  shamt  = imem_data[10:6];
    wire [5:0]  func   = imem_data[5:0];
    wire [15:0] imm    = imem_data[15:0];

    assign imem_addr = pc;
    assign pc_plus4  = pc + 32'd4;

    rcore_decode u_dec (
        .opcode (opcode),
        .func   (func),
        .shamt  (shamt),
        .zero   (zero),
        .ctrl   (ctrl)
    );

    rcore_regfile #(.NREG(NREG), .W(XLEN)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_addr (AW'(rs)),
        .ra_data (rs_val),
        .rb_addr (AW'(rt)),
        .rb_data (rt_val),
        .we      (rf_we),
        .waddr   (rf_waddr),
        .wdata   (wb_data)
    );

    // Extend the 16-bit immediate per the selected mode.
    always_comb begin
        unique case (ctrl.ext_sel)
            EXT_ZERO: imm_ext = {16'h0, imm};
            EXT_HIGH: imm_ext = {imm, 16'h0};
            default:  imm_ext = {{16{imm[15]}}, imm};
        endcase
    end

    assign b_opnd = (ctrl.b_src == B_IMM) ? imm_ext : rt_val;

    rcore_alu #(.W(XLEN)) u_alu (
        .a    (rs_val),
        .b    (b_opnd),
        .op   (ctrl.alu_op),
        .y    (alu_y),
        .zero (zero)
    );

    // Pick the destination register index.
    always_comb begin
        unique case (ctrl.reg_dst)
            DST_RD:   rf_waddr = AW'(rd);
            DST_LINK: rf_waddr = AW'(NREG - 1);
            default:  rf_waddr = AW'(rt);
        endcase
    end

    // Pick the write-back value.
    always_comb begin
        unique case (ctrl.wb_src)
            WB_MEM:  wb_data = dmem_rdata;
            WB_PC4:  wb_data = pc_plus4;
            default: wb_data = alu_y;
        endcase
    end

    // Select the next PC.
    always_comb begin
        unique case (ctrl.pc_src)
            PC_BR:   pc_next = pc_plus4 + {{14{imm[15]}}, imm, 2'b00};
            PC_IND:  pc_next = rs_val;
            PC_ABS:  pc_next = {pc_plus4[31:28], imem_data[25:0], 2'b00};
            default: pc_next = pc_plus4;
        endcase
    end

    // Program counter register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= RESET_PC;
        else
            pc <= pc_next;
    end

    assign rf_we      = ctrl.reg_we & rst_n;
    assign dmem_we    = ctrl.mem_we & rst_n;
    assign dmem_addr  = alu_y;
    assign dmem_wdata = rt_val;

    // R2
    seq_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.pc_src == PC_SEQ) |=> (imem_addr == $past(imem_addr) + 32'd4));

    // R7
    br_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_BEQZ && rs_val == 32'd0) |=>
        (imem_addr == $past(imem_addr + 32'd4 + {{14{imm[15]}}, imm, 2'b00})));

    // R6
    store_no_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_SW) |-> (dmem_we && !rf_we));

    // R8
    link_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode == OP_JAL) |->
        (rf_we && rf_waddr == AW'(NREG - 1) && wb_data == imem_addr + 32'd4));

    // R10
    illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl.illegal |-> (!dmem_we && !rf_we));

endmodule

// File: tb/rcore_top_bench.sv
`timescale 1ns/1ps
// Lockstep bench: builds a program sweeping operand grids, runs a
// reference instruction model beside the core and compares PC and every
// data-memory access each cycle, then the whole data memory.
module rcore_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] imem_addr, imem_data, dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [31:0] imem [2048];
    logic [31:0] dmem [256];
    logic [31:0] m_dmem [256];
    logic [31:0] m_reg [32];
    logic [31:0] m_pc;
    int          n_prog = 0;
    int          sc = 0;
    int          n_vec = 0;
    int          n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    rcore_top u_rcore_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .imem_addr  (imem_addr),
        .imem_data  (imem_data),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_data  = imem[imem_addr[12:2]];
    assign dmem_rdata = dmem[dmem_addr[9:2]];

    always @(posedge clk) if (dmem_we) dmem[dmem_addr[9:2]] <= dmem_wdata;

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int s, input int t, input int d);
        return {6'h00, 5'(s), 5'(t), 5'(d), 5'd0, fn};
    endfunction
    function automatic logic [31:0] enc_i(input logic [5:0] op, input int s, input int t, input logic [15:0] im);
        return {op, 5'(s), 5'(t), im};
    endfunction

    task automatic emit(input logic [31:0] w);
        imem[n_prog] = w;
        n_prog++;
    endtask
    task automatic emit_store(input int r);
        emit(enc_i(6'h2B, 0, r, 16'((sc % 64) * 4)));
        sc++;
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s at pc=%08h: actual=%08h expected=%08h", req, what, m_pc, act, exp);
        end
    endtask

    // Reference model: check this cycle's memory access, then retire one instruction.
    task automatic step();
        logic [31:0] w, rsv, rtv, sx, zx, npc, addr, wv;
        logic [5:0]  op, fn;
        int          s, t, d, widx;
        bit          st, ld;
        string       tag;
        w = imem[m_pc[12:2]];
        op = w[31:26]; fn = w[5:0];
        s = int'(w[25:21]); t = int'(w[20:16]); d = int'(w[15:11]);
        rsv = m_reg[s]; rtv = m_reg[t];
        sx = {{16{w[15]}}, w[15:0]}; zx = {16'h0, w[15:0]};
        npc = m_pc + 4; widx = 0; wv = 0; st = 0; ld = 0; addr = 0;
        tag = "R10";
        case (op)
            6'h00: if (w[10:6] == 0) begin
                tag = "R3";
                case (fn)
                    6'h20: begin widx = d; wv = rsv + rtv; end
                    6'h22: begin widx = d; wv = rsv - rtv; end
                    6'h24: begin widx = d; wv = rsv & rtv; end
                    6'h25: begin widx = d; wv = rsv | rtv; end
                    6'h26: begin widx = d; wv = rsv ^ rtv; end
                    6'h2A: begin widx = d; wv = ($signed(rsv) < $signed(rtv)) ? 1 : 0; end
                    6'h08: begin tag = "R9"; npc = rsv; end
                    6'h09: begin tag = "R9"; npc = rsv; widx = 31; wv = m_pc + 4; end
                    default: tag = "R10";
                endcase
            end
            6'h08: begin tag = "R4"; widx = t; wv = rsv + sx; end
            6'h0A: begin tag = "R4"; widx = t; wv = ($signed(rsv) < $signed(sx)) ? 1 : 0; end
            6'h0C: begin tag = "R4"; widx = t; wv = rsv & zx; end
            6'h0D: begin tag = "R4"; widx = t; wv = rsv | zx; end
            6'h0E: begin tag = "R4"; widx = t; wv = rsv ^ zx; end
            6'h0F: begin tag = "R4"; widx = t; wv = {w[15:0], 16'h0}; end
            6'h23: begin tag = "R6"; ld = 1; addr = rsv + sx; widx = t; wv = m_dmem[addr[9:2]]; end
            6'h2B: begin tag = "R6"; st = 1; addr = rsv + sx; end
            6'h04: begin tag = "R7"; if (rsv == 0) npc = m_pc + 4 + (sx << 2); end
            6'h05: begin tag = "R7"; if (rsv != 0) npc = m_pc + 4 + (sx << 2); end
            6'h02: begin tag = "R8"; npc = {m_pc[31:28] + 4'(0), w[25:0], 2'b00}; end
            6'h03: begin tag = "R8"; npc = {m_pc[31:28], w[25:0], 2'b00}; widx = 31; wv = m_pc + 4; end
            default: tag = "R10";
        endcase
        if (widx == 0 && (op == 6'h00 || op == 6'h08 || op == 6'h23) && tag != "R10" && tag != "R9")
            tag = (t == 0 || d == 0) ? "R5" : tag;
        chk(tag, "dmem_we", {31'd0, dmem_we}, {31'd0, st});
        if (st) begin
            chk(tag, "store addr", dmem_addr, addr);
            // R11: store data reflects the most recent register write
            chk(tag, "store data", dmem_wdata, rtv);
            m_dmem[addr[9:2]] = rtv;
        end
        if (ld) chk(tag, "load addr", dmem_addr, addr);
        if (widx != 0) m_reg[widx] = wv;
        m_pc = npc;
    endtask

    task automatic build();
        logic [31:0] cv [8];
        logic [15:0] iv [6];
        logic [5:0]  rf [6];
        logic [5:0]  io [6];
        int cnt, p;
        cv = '{32'h0000_0001, 32'hFFFF_FFFF, 32'h7FFF_FFFF, 32'h8000_0000,
               32'h1234_5678, 32'hFFFF_8000, 32'h0000_7FFF, 32'hA5A5_0F0F};
        iv = '{16'h0000, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFF, 16'h1234};
        rf = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h26, 6'h2A};
        io = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E, 6'h0F};
        for (int i = 0; i < 2048; i++) imem[i] = 32'h0;
        emit(enc_i(6'h2B, 0, 0, 16'h0004));           // R1: store at reset boundary
        for (int k = 1; k <= 8; k++) begin
            emit(enc_i(6'h0F, 0, k, cv[k-1][31:16]));
            emit(enc_i(6'h0D, k, k, cv[k-1][15:0]));
        end
        cnt = 0;
        for (int a = 1; a <= 8; a++)                  // R3 sweep
            for (int b = 1; b <= 8; b++)
                for (int f = 0; f < 6; f++) begin
                    emit(enc_r(rf[f], a, b, 9 + cnt % 20));
                    emit_store(9 + cnt % 20);
                    cnt++;
                end
        for (int a = 1; a <= 8; a++)                  // R4 sweep
            for (int m = 0; m < 6; m++)
                for (int o = 0; o < 6; o++) begin
                    emit(enc_i(io[o], a, 9 + cnt % 20, iv[m]));
                    emit_store(9 + cnt % 20);
                    cnt++;
                end
        // R5: writes to register 0 are dropped
        emit(enc_i(6'h08, 1, 0, 16'h0005)); emit_store(0);
        emit(enc_r(6'h20, 2, 2, 0));        emit_store(0);
        emit(enc_i(6'h23, 0, 0, 16'h0008)); emit_store(0);
        // R6: loads with zero, positive and negative displacement
        emit(enc_i(6'h23, 0, 20, 16'h0008)); emit_store(20);
        emit(enc_i(6'h08, 0, 21, 16'h0040));
        emit(enc_i(6'h23, 21, 22, 16'hFFFC)); emit_store(22);
        emit(enc_i(6'h23, 21, 22, 16'h0010)); emit_store(22);
        // R7: taken and untaken both ways, then a backward loop
        emit(enc_i(6'h08, 0, 23, 16'h0000));
        emit(enc_i(6'h04, 0, 0, 16'h0001)); emit(enc_i(6'h08, 0, 23, 16'h0055));
        emit(enc_i(6'h05, 1, 0, 16'h0001)); emit(enc_i(6'h08, 0, 23, 16'h0066));
        emit(enc_i(6'h04, 1, 0, 16'h0001)); emit(enc_i(6'h08, 23, 23, 16'h0011));
        emit(enc_i(6'h05, 0, 0, 16'h0001)); emit(enc_i(6'h08, 23, 23, 16'h0001));
        emit_store(23);
        emit(enc_i(6'h08, 0, 24, 16'h0003));
        emit(enc_i(6'h08, 24, 24, 16'hFFFF));
        emit(enc_i(6'h05, 24, 0, 16'hFFFE));
        emit_store(24);
        // R8: plain jump and jump-and-link over poison
        p = n_prog; emit({6'h02, 26'(p + 2)}); emit(enc_i(6'h08, 0, 23, 16'h0077));
        p = n_prog; emit({6'h03, 26'(p + 2)}); emit(enc_i(6'h08, 0, 23, 16'h0088));
        emit_store(31); emit_store(23);
        // R9: register-indirect jumps
        p = n_prog; emit(enc_i(6'h08, 0, 25, 16'((p + 3) * 4)));
        emit(enc_r(6'h08, 25, 0, 0)); emit(enc_i(6'h08, 0, 23, 16'h0099));
        p = n_prog; emit(enc_i(6'h08, 0, 25, 16'((p + 3) * 4)));
        emit(enc_r(6'h09, 25, 0, 0)); emit(enc_i(6'h08, 0, 23, 16'h00AA));
        emit_store(31); emit_store(23);
        // R10: unknown opcode, unknown function, nonzero shamt
        emit(32'hFC00_0000);
        emit(enc_r(6'h3F, 1, 1, 23));
        emit(enc_r(6'h20, 1, 1, 23) | 32'h0000_0040);
        emit_store(23);
        for (int k = 1; k < 32; k++) emit(enc_i(6'h2B, 0, k, 16'((64 + k) * 4)));
        emit({6'h02, 26'(n_prog)});
    endtask

    initial begin
        int halt_pc, cyc;
        for (int i = 0; i < 256; i++) begin dmem[i] = 32'h0; m_dmem[i] = 32'h0; end
        for (int i = 0; i < 32; i++) m_reg[i] = 32'h0;
        m_pc = 32'h0;
        build();
        halt_pc = (n_prog - 1) * 4;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: PC cleared and no store while reset is held
        chk("R1", "pc in reset", imem_addr, 32'h0);
        chk("R1", "dmem_we in reset", {31'd0, dmem_we}, 32'd0);
        rst_n = 1'b1;
        #1;
        cyc = 0;
        while (cyc < 5000 && !(m_pc == 32'(halt_pc) && cyc > 0)) begin
            // R2: instruction address follows the reference PC
            chk("R2", "pc", imem_addr, m_pc);
            step();
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 5000) chk("R2", "halt reached", m_pc, 32'(halt_pc));
        repeat (3) begin
            chk("R8", "halt loop pc", imem_addr, m_pc);
            step();
            @(negedge clk);
        end
        // R6: final data memory matches the model
        for (int i = 0; i < 256; i++) chk("R6", "final dmem", dmem[i], m_dmem[i]);
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_vec++; n_bad++;
            $display("FAIL R2 watchdog expired: actual=running expected=halted");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule